// File: doc/BRIEF.md
# Relaxed-Timing Chip-Select Strobe Sequencer

This block drives the control strobes of one external memory bank for a single access: chip-select, a write-enable line that can double as a byte enable, output-enable and a one-bus-clock transfer acknowledge. It runs on a clock four times faster than the bus clock. Each bus clock is therefore made of four quarter ticks, and strobe edges can be placed on quarter-clock boundaries.

A one-tick `start_i` pulse begins an access while the block is idle. In the same tick the block captures the direction and the bank settings: a wait-state count, a relaxed-timing enable, a two-bit chip-select setup code and a byte-enable mode bit. The access length in bus clocks is L = 2 + W×(relax ? 2 : 1) + relax. Relaxed timing pushes the write-enable and chip-select assertion one bus clock later. The setup code can delay chip-select by a further quarter or half bus clock. `busy_o` stays high for the whole access.

The block has no data stream, so it has no valid/ready handshake and no back-pressure. The start pulse is a plain control input. A pulse that arrives while `busy_o` is high is dropped. Quarter k of an access is the (k+1)-th quarter tick after the clock edge that accepted the start. All outputs are registered and active high.

Top module: `rc_strobe_seq`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge) drives `cs_o`, `we_o`, `oe_o`, `ta_o` and `busy_o` low from the next tick. A reset in the middle of an access ends that access.
- R2: An access accepted with wait count W and relax flag X keeps `busy_o` high for exactly 4×L quarter ticks, where L = 2 + W×(X ? 2 : 1) + X.
- R3: `ta_o` is high for exactly the last four quarters of each access (quarters 4L−4 to 4L−1) and low at all other times.
- R4: `cs_o` rises at quarter 4×X + D and stays high through quarter 4L−1. D is the setup delay given in R5.
- R5: The setup code `setup_i` gives the extra chip-select delay D in quarters: 2'b00 gives 0, 2'b01 (reserved) gives 0, 2'b10 gives 1 and 2'b11 gives 2.
- R6: On a write (`rd_i` = 0), `we_o` is high from quarter 4×X through quarter 4L−1. On a read, `we_o` follows the same window when `bemode_i` = 1 and stays low when `bemode_i` = 0.
- R7: `oe_o` is high only on reads, from the chip-select assertion quarter through quarter 4L−1. It stays low on writes.
- R8: A `start_i` pulse while `busy_o` is high is ignored. Changes to the direction or settings inputs after the start tick have no effect on the access in progress.
- R9: In the first tick after an access ends, `busy_o` and every strobe are low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Quarter-rate clock (four ticks per bus clock) |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Access start pulse, accepted only while idle |
| rd_i | input | 1 | Direction: 1 = read, 0 = write |
| wait_i | input | WAIT_W | Programmed wait-state count |
| relax_i | input | 1 | Relaxed-timing enable |
| setup_i | input | 2 | Chip-select setup delay code |
| bemode_i | input | 1 | Write-enable acts as byte enable (also on reads) |
| cs_o | output | 1 | Chip-select strobe |
| we_o | output | 1 | Write-enable / byte-enable strobe |
| oe_o | output | 1 | Output-enable strobe |
| ta_o | output | 1 | Transfer acknowledge |
| busy_o | output | 1 | Access in progress |

## Verification
The assertions check the ordering relations on every cycle. Acknowledge never appears outside an access, and it lasts exactly four ticks and ends together with busy. Chip-select and write-enable never drop before the end of the access, output-enable is never high without chip-select, and the strobes are all low while idle and after reset. The quarter-exact positions depend on the settings captured at the start: the access length from the wait count and relax flag, the chip-select offset for each setup code, byte-enable on reads, and the discarding of start pulses and setting changes mid-access. Only the bench's reference model and its directed scenarios can show these.

// File: rtl/rc_pkg.sv
package rc_pkg;
  // quarter ticks per bus clock
  localparam int unsigned QPC = 4;

  typedef enum logic [1:0] {
    SETUP_NONE = 2'b00,
    SETUP_RSVD = 2'b01,
    SETUP_QTR  = 2'b10,
    SETUP_HALF = 2'b11
  } setup_e;

  // strobe lane indices
  localparam int unsigned LANE_CS = 0;
  localparam int unsigned LANE_WE = 1;
  localparam int unsigned LANE_OE = 2;
  localparam int unsigned LANE_TA = 3;
  localparam int unsigned LANES   = 4;

  // extra chip-select delay in quarters for a setup code
  function automatic logic [1:0] setup_quarters(input logic [1:0] code);
    logic [1:0] d;
    case (setup_e'(code))
      SETUP_QTR:  d = 2'd1;
      SETUP_HALF: d = 2'd2;
      default:    d = 2'd0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/rc_cfg_latch.sv
// Captures the bank settings at the start of an access and derives the
// quarter index of each strobe edge. The next_* outputs show the value the
// registers hold after the current edge, so output flops can be fed from it.
module rc_cfg_latch #(
  parameter int unsigned WAIT_W = 4,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              accept_i,
  input  logic              rd_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic              relax_i,
  input  logic [1:0]        setup_i,
  input  logic              bemode_i,
  output logic              next_rd_o,
  output logic              next_ween_o,
  output logic [CNT_W-1:0]  next_cs_at_o,
  output logic [CNT_W-1:0]  next_we_at_o,
  output logic [CNT_W-1:0]  next_ta_at_o,
  output logic [CNT_W-1:0]  cur_last_o
);
  import rc_pkg::*;

  localparam int unsigned QSH = $clog2(QPC);

  logic [CNT_W-1:0] wq, wscaled, len_in;
  logic [CNT_W-1:0] cs_at_in, we_at_in, ta_at_in, last_in;

  logic             rd_q, ween_q;
  logic [CNT_W-1:0] cs_at_q, we_at_q, ta_at_q, last_q;

  always_comb begin
    wq       = CNT_W'(wait_i);
    wscaled  = relax_i ? (wq << 1) : wq;
    len_in   = CNT_W'(2) + wscaled + CNT_W'(relax_i);
    last_in  = (len_in << QSH) - CNT_W'(1);
    ta_at_in = (len_in - CNT_W'(1)) << QSH;
    we_at_in = relax_i ? CNT_W'(QPC) : '0;
    cs_at_in = we_at_in + CNT_W'(setup_quarters(setup_i));
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rd_q    <= 1'b0;
      ween_q  <= 1'b0;
      cs_at_q <= '0;
      we_at_q <= '0;
      ta_at_q <= '0;
      last_q  <= '0;
    end else if (accept_i) begin
      rd_q    <= rd_i;
      ween_q  <= ~rd_i | bemode_i;
      cs_at_q <= cs_at_in;
      we_at_q <= we_at_in;
      ta_at_q <= ta_at_in;
      last_q  <= last_in;
    end
  end

  assign next_rd_o    = accept_i ? rd_i                 : rd_q;
  assign next_ween_o  = accept_i ? (~rd_i | bemode_i)   : ween_q;
  assign next_cs_at_o = accept_i ? cs_at_in             : cs_at_q;
  assign next_we_at_o = accept_i ? we_at_in             : we_at_q;
  assign next_ta_at_o = accept_i ? ta_at_in             : ta_at_q;
  assign cur_last_o   = last_q;
endmodule

// File: rtl/rc_quarter_seq.sv
// Quarter-tick counter for one access: accepts a start while idle and stops
// after the last quarter of the access.
module rc_quarter_seq #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] last_i,
  output logic             accept_o,
  output logic             next_active_o,
  output logic [CNT_W-1:0] next_q_o
);
  logic             active_q;
  logic [CNT_W-1:0] q_q;
  logic             at_end;

  assign accept_o = start_i & ~active_q;
  assign at_end   = active_q & (q_q == last_i);

  always_comb begin
    next_active_o = active_q;
    next_q_o      = q_q;
    if (rst_i) begin
      next_active_o = 1'b0;
      next_q_o      = '0;
    end else if (accept_o) begin
      next_active_o = 1'b1;
      next_q_o      = '0;
    end else if (at_end) begin
      next_active_o = 1'b0;
      next_q_o      = '0;
    end else if (active_q) begin
      next_q_o      = q_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    active_q <= next_active_o;
    q_q      <= next_q_o;
  end
endmodule

// File: rtl/rc_strobe_gen.sv
// Registered strobe lanes: each lane is high from its threshold quarter to
// the end of the access, gated by its enable.
module rc_strobe_gen #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             next_active_i,
  input  logic [CNT_W-1:0] next_q_i,
  input  logic             next_rd_i,
  input  logic             next_ween_i,
  input  logic [CNT_W-1:0] next_cs_at_i,
  input  logic [CNT_W-1:0] next_we_at_i,
  input  logic [CNT_W-1:0] next_ta_at_i,
  output logic             cs_o,
  output logic             we_o,
  output logic             oe_o,
  output logic             ta_o,
  output logic             busy_o
);
  import rc_pkg::*;

  logic [CNT_W-1:0] thr [LANES];
  logic [LANES-1:0] ena;
  logic [LANES-1:0] lane_q;
  logic             busy_q;

  always_comb begin
    thr[LANE_CS] = next_cs_at_i;
    thr[LANE_WE] = next_we_at_i;
    thr[LANE_OE] = next_cs_at_i;
    thr[LANE_TA] = next_ta_at_i;
    ena[LANE_CS] = 1'b1;
    ena[LANE_WE] = next_ween_i;
    ena[LANE_OE] = next_rd_i;
    ena[LANE_TA] = 1'b1;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i) begin
      if (rst_i) lane_q[g] <= 1'b0;
      else       lane_q[g] <= next_active_i & ena[g] & (next_q_i >= thr[g]);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) busy_q <= 1'b0;
    else       busy_q <= next_active_i;
  end

  assign cs_o   = lane_q[LANE_CS];
  assign we_o   = lane_q[LANE_WE];
  assign oe_o   = lane_q[LANE_OE];
  assign ta_o   = lane_q[LANE_TA];
  assign busy_o = busy_q;
endmodule

// File: rtl/rc_strobe_seq.sv
module rc_strobe_seq #(
  parameter int unsigned WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic              relax_i,
  input  logic [1:0]        setup_i,
  input  logic              bemode_i,
  output logic              cs_o,
  output logic              we_o,
  output logic              oe_o,
  output logic              ta_o,
  output logic              busy_o
);
  import rc_pkg::*;

  localparam int unsigned MAX_LEN = 2 + 2 * ((2 ** WAIT_W) - 1) + 1;
  localparam int unsigned CNT_W   = $clog2(QPC * MAX_LEN + 1);

  logic             accept;
  logic             nx_active;
  logic [CNT_W-1:0] nx_q;
  logic             nx_rd, nx_ween;
  logic [CNT_W-1:0] nx_cs_at, nx_we_at, nx_ta_at, cur_last;

  rc_quarter_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .start_i       (start_i),
    .last_i        (cur_last),
    .accept_o      (accept),
    .next_active_o (nx_active),
    .next_q_o      (nx_q)
  );

  rc_cfg_latch #(.WAIT_W(WAIT_W), .CNT_W(CNT_W)) u_cfg (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .accept_i     (accept),
    .rd_i         (rd_i),
    .wait_i       (wait_i),
    .relax_i      (relax_i),
    .setup_i      (setup_i),
    .bemode_i     (bemode_i),
    .next_rd_o    (nx_rd),
    .next_ween_o  (nx_ween),
    .next_cs_at_o (nx_cs_at),
    .next_we_at_o (nx_we_at),
    .next_ta_at_o (nx_ta_at),
    .cur_last_o   (cur_last)
  );

  rc_strobe_gen #(.CNT_W(CNT_W)) u_gen (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .next_active_i (nx_active),
    .next_q_i      (nx_q),
    .next_rd_i     (nx_rd),
    .next_ween_i   (nx_ween),
    .next_cs_at_i  (nx_cs_at),
    .next_we_at_i  (nx_we_at),
    .next_ta_at_i  (nx_ta_at),
    .cs_o          (cs_o),
    .we_o          (we_o),
    .oe_o          (oe_o),
    .ta_o          (ta_o),
    .busy_o        (busy_o)
  );
endmodule

// File: rtl/rc_strobe_chk.sv
module rc_strobe_chk (
  input logic clk_i,
  input logic rst_i,
  input logic cs_o,
  input logic we_o,
  input logic oe_o,
  input logic ta_o,
  input logic busy_o
);
  logic [2:0] ta_run;

  always_ff @(posedge clk_i) begin
    if (rst_i)                      ta_run <= '0;
    else if (!ta_o)                 ta_run <= '0;
    else if (ta_run != 3'd7)        ta_run <= ta_run + 3'd1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    rst_i |=> (!busy_o && !cs_o && !we_o && !oe_o && !ta_o)); // R1

  AST_TA_IN_ACCESS: assert property (@(posedge clk_i) disable iff (rst_i)
    ta_o |-> busy_o); // R3

  AST_TA_FOUR_TICKS: assert property (@(posedge clk_i) disable iff (rst_i)
    ($fell(ta_o) && !$past(rst_i)) |-> (ta_run == 3'd4)); // R3

  AST_TA_ENDS_ACCESS: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(ta_o) |-> $fell(busy_o)); // R3

  AST_CS_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(cs_o) |-> !busy_o); // R4

  AST_WE_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(we_o) |-> !busy_o); // R6

  AST_OE_UNDER_CS: assert property (@(posedge clk_i) disable iff (rst_i)
    oe_o |-> cs_o); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    !busy_o |-> (!cs_o && !we_o && !oe_o && !ta_o)); // R9
endmodule

bind rc_strobe_seq rc_strobe_chk u_chk (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .cs_o   (cs_o),
  .we_o   (we_o),
  .oe_o   (oe_o),
  .ta_o   (ta_o),
  .busy_o (busy_o)
);

// File: tb/sim_rc_strobe_seq.sv
`timescale 1ns/1ps
module sim_rc_strobe_seq;
  localparam int WAIT_W = 4;

  logic clk = 1'b0;
  logic rst_i = 1'b1, start_i = 1'b0, rd_i = 1'b0, relax_i = 1'b0, bemode_i = 1'b0;
  logic [WAIT_W-1:0] wait_i = '0;
  logic [1:0] setup_i = 2'b00;
  logic cs_o, we_o, oe_o, ta_o, busy_o;

  always #5 clk = ~clk;

  rc_strobe_seq #(.WAIT_W(WAIT_W)) u0 (
    .clk_i(clk), .rst_i(rst_i), .start_i(start_i), .rd_i(rd_i), .wait_i(wait_i),
    .relax_i(relax_i), .setup_i(setup_i), .bemode_i(bemode_i),
    .cs_o(cs_o), .we_o(we_o), .oe_o(oe_o), .ta_o(ta_o), .busy_o(busy_o));

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  // behavioural reference state
  bit m_act = 0, m_rd = 0, m_be = 0, m_rel = 0, m_rstseen = 0;
  int m_k = 0, m_len = 0, m_d = 0;

  function automatic int len_of(int w, bit rel);
    return 2 + w * (rel ? 2 : 1) + (rel ? 1 : 0);
  endfunction
  function automatic int dly_of(logic [1:0] s);
    return (s == 2'b10) ? 1 : (s == 2'b11) ? 2 : 0;
  endfunction

  always @(posedge clk) begin
    m_rstseen = rst_i;
    if (rst_i) m_act = 0;
    else if (m_act) begin
      if (m_k == 4 * m_len - 1) m_act = 0;
      else m_k++;
    end else if (start_i) begin
      m_act = 1; m_k = 0; m_rd = rd_i; m_be = bemode_i; m_rel = relax_i;
      m_len = len_of(int'(wait_i), relax_i); m_d = dly_of(setup_i);
    end
  end

  task automatic chk(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_int(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    bit e_cs, e_we, e_oe, e_ta, e_busy;
    int csq, weq;
    csq = 4 * (m_rel ? 1 : 0) + m_d;
    weq = 4 * (m_rel ? 1 : 0);
    e_busy = m_act;
    e_cs = m_act && (m_k >= csq);
    e_we = m_act && (!m_rd || m_be) && (m_k >= weq);
    e_oe = m_act && m_rd && (m_k >= csq);
    e_ta = m_act && (m_k >= 4 * m_len - 4);
    if (m_rstseen) begin
      chk("R1", busy_o | cs_o | we_o | oe_o | ta_o, 1'b0, "outputs during reset");
    end else begin
      chk("R2", busy_o, e_busy, "busy");
      chk("R4", cs_o, e_cs, "cs");
      chk("R6", we_o, e_we, "we");
      chk("R7", oe_o, e_oe, "oe");
      chk("R3", ta_o, e_ta, "ta");
    end
  end

  task automatic run_access(bit rd, int w, bit rel, logic [1:0] su, bit be, bit poke);
    int n, first_cs, exp_len;
    string ltag, ctag;
    @(negedge clk);
    rd_i = rd; wait_i = WAIT_W'(w); relax_i = rel; setup_i = su; bemode_i = be;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // scramble settings after the start tick: must not matter (R8)
    rd_i = ~rd; wait_i = ~WAIT_W'(w); relax_i = ~rel; setup_i = ~su; bemode_i = ~be;
    n = 0; first_cs = -1;
    while (busy_o && n < 1000) begin
      if (cs_o && first_cs < 0) first_cs = n;
      start_i = (poke && (n == 3 || n == 4));
      n++;
      @(negedge clk);
    end
    start_i = 1'b0;
    exp_len = 4 * len_of(w, rel);
    ltag = poke ? "R8" : "R2";
    chk_int(ltag, n, exp_len, "access length in quarters");
    ctag = su[1] ? "R5" : "R4";
    chk_int(ctag, first_cs, 4 * (rel ? 1 : 0) + dly_of(su), "first cs quarter");
    chk("R9", cs_o | we_o | oe_o | ta_o, 1'b0, "strobes after end");
    @(negedge clk);
    chk("R8", busy_o, 1'b0, "no restart from pulse during access");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_i = 1'b0;
    @(negedge clk);
    chk("R1", busy_o, 1'b0, "busy after reset");

    run_access(0, 1, 1, 2'b10, 0, 0);   // 5-clock relaxed write
    run_access(1, 0, 1, 2'b00, 0, 0);   // 3-clock relaxed read
    run_access(1, 0, 0, 2'b11, 1, 0);   // read with byte-enable mode
    run_access(0, 0, 0, 2'b00, 0, 0);   // minimum write
    run_access(1, 3, 0, 2'b01, 0, 0);   // reserved code acts as none
    run_access(0, 15, 1, 2'b11, 0, 0);  // longest access
    run_access(1, 2, 1, 2'b10, 1, 1);   // ignored start during access
    run_access(0, 4, 0, 2'b10, 0, 1);
    for (int s = 0; s < 4; s++)
      for (int r = 0; r < 2; r++)
        for (int d = 0; d < 2; d++)
          run_access(d[0], 1, r[0], 2'(s), s[0], 0);

    // reset in the middle of an access (R1)
    @(negedge clk);
    rd_i = 1; wait_i = 4'd3; relax_i = 1; setup_i = 2'b10; bemode_i = 1; start_i = 1;
    @(negedge clk); start_i = 0;
    repeat (9) @(negedge clk);
    rst_i = 1;
    @(negedge clk); rst_i = 0;
    chk("R1", busy_o | cs_o | we_o | oe_o | ta_o, 1'b0, "outputs after mid-access reset");
    repeat (2) @(negedge clk);
    run_access(0, 2, 0, 2'b11, 0, 0);

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule